// File: doc/BRIEF.md
# Prioritized Interrupt Flag Controller

This block gathers eight interrupt sources of a bus controller into one active-low interrupt line. Each source has an enable bit and a sticky flag bit at the same bit position. Hardware strobes set the flags. A flag whose source condition is still active cannot be cleared. The host can also set flags in software to raise an interrupt on purpose.

A small register port gives the host both registers. It can read them, overwrite them in full, or apply a masked bit-modify write. The mask lets the host clear one flag without disturbing another flag that hardware sets during the same access.

A 3-bit code reports the highest-priority source that is both pending and enabled, so a service routine can dispatch without scanning. While the controller sleeps, bus activity on an enabled wakeup source sets the wakeup flag and pulses a sleep-exit request.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset, both registers read 0x00, `irq_no` is 1, `icode_o` is 000 and `wake_req_o` is 0.
- R2: A one-cycle strobe on `evt_i[i]` sets flag bit i on the next rising edge. The flag then stays set after the strobe ends.
- R3: Bit positions are the same in both registers: 0 rx buffer 0, 1 rx buffer 1, 2 tx buffer 0, 3 tx buffer 1, 4 tx buffer 2, 5 wakeup, 6 error, 7 message error. `reg_sel_i`=0 selects the enable register and 1 selects the flag register. A full write replaces the selected register, and `reg_rdata_o` returns it.
- R4: A bit-modify write (`reg_mod_i`=1) changes only the bits set in `reg_mask_i`. Every other bit of the selected register keeps its value.
- R5: `irq_no` is 0 exactly when some flag and its enable are both set. This includes flags set by a host write.
- R6: A write of 0 to a flag has no effect while `cond_i` for that bit is 1.
- R7: If a strobe and a host clear of the same flag occur in the same cycle, the flag ends up set.
- R8: `icode_o` maps sources to codes as follows: 001 error, 010 wakeup, 011 tx0, 100 tx1, 101 tx2, 110 rx0, 111 rx1. Code 000 means nothing is pending. A lower nonzero code wins.
- R9: Only enabled sources take part in `icode_o`. When the winning flag is cleared, the code moves to the next pending enabled source.
- R10: The message-error source never appears in `icode_o`, but it drives `irq_no` low when it is both flagged and enabled.
- R11: When `sleep_i`, `bus_act_i` and the wakeup enable are all 1, the wakeup flag is set and `wake_req_o` is 1 for exactly one cycle. Outside sleep, or with the wakeup enable clear, bus activity does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_sel_i | input | 1 | Register select: 0 enables, 1 flags |
| reg_wr_i | input | 1 | Write strobe |
| reg_mod_i | input | 1 | Apply the write through `reg_mask_i` |
| reg_mask_i | input | 8 | Bit-modify mask |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Selected register, combinational |
| evt_i | input | 8 | Per-source set strobes |
| cond_i | input | 8 | Per-source persistent condition levels |
| sleep_i | input | 1 | Controller is asleep |
| bus_act_i | input | 1 | Bus activity seen |
| irq_no | output | 1 | Interrupt request, active low |
| icode_o | output | 3 | Code of the winning pending source |
| wake_req_o | output | 1 | Sleep-exit request pulse |

## Verification
Writes, strobes and wakeup detection take effect on the first rising edge after they are presented. `irq_no` and `icode_o` follow the registered flags with no further delay, so they are due at that same edge. `wake_req_o` is high for the cycle that follows that edge. The bench drives inputs on falling edges and samples results on the next falling edge, when each of them has settled. Reads are combinational and are sampled shortly after `reg_sel_i` changes.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned SRC_N  = 8;
  localparam int unsigned CODE_W = 3;
  localparam int unsigned CODE_N = 1 << CODE_W;

  localparam int unsigned B_RX0  = 0;
  localparam int unsigned B_RX1  = 1;
  localparam int unsigned B_TX0  = 2;
  localparam int unsigned B_TX1  = 3;
  localparam int unsigned B_TX2  = 4;
  localparam int unsigned B_WAKE = 5;
  localparam int unsigned B_ERR  = 6;
  localparam int unsigned B_MERR = 7;

  // source bit reported by each nonzero code; code 0 has no source
  function automatic int unsigned code_src(input logic [CODE_W-1:0] c);
    case (c)
      3'd1:    return B_ERR;
      3'd2:    return B_WAKE;
      3'd3:    return B_TX0;
      3'd4:    return B_TX1;
      3'd5:    return B_TX2;
      3'd6:    return B_RX0;
      3'd7:    return B_RX1;
      default: return B_MERR;
    endcase
  endfunction
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned N = irq_pkg::SRC_N
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_we_i,
  input  logic         fl_we_i,
  input  logic [N-1:0] mask_i,
  input  logic [N-1:0] wdata_i,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] hold_i,
  output logic [N-1:0] en_o,
  output logic [N-1:0] flag_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic en_q, fl_q, fl_d;

    always_comb begin
      fl_d = fl_q;
      if (fl_we_i && mask_i[i]) fl_d = wdata_i[i] | (fl_q & hold_i[i]);
      fl_d = fl_d | set_i[i];  // hardware set beats host clear
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q <= 1'b0;
        fl_q <= 1'b0;
      end else begin
        if (en_we_i && mask_i[i]) en_q <= wdata_i[i];
        fl_q <= fl_d;
      end
    end

    assign en_o[i]   = en_q;
    assign flag_o[i] = fl_q;
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned N      = irq_pkg::SRC_N,
  parameter int unsigned CODE_W = irq_pkg::CODE_W
) (
  input  logic [N-1:0]      pend_i,
  output logic [CODE_W-1:0] code_o
);
  localparam int unsigned CODE_N = 1 << CODE_W;

  always_comb begin
    code_o = '0;
    for (int k = CODE_N - 1; k >= 1; k--) begin
      if (pend_i[irq_pkg::code_src(CODE_W'(k))]) code_o = CODE_W'(k);
    end
  end
endmodule

// File: rtl/irq_wake_det.sv
module irq_wake_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleep_i,
  input  logic bus_act_i,
  input  logic wake_en_i,
  output logic det_o,
  output logic req_o
);
  logic det_q;

  assign det_o = sleep_i & bus_act_i & wake_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      det_q <= 1'b0;
      req_o <= 1'b0;
    end else begin
      det_q <= det_o;
      req_o <= det_o & ~det_q;  // one pulse per detection
    end
  end
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl #(
  parameter int unsigned SRC_N  = irq_pkg::SRC_N,
  parameter int unsigned CODE_W = irq_pkg::CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_sel_i,
  input  logic              reg_wr_i,
  input  logic              reg_mod_i,
  input  logic [SRC_N-1:0]  reg_mask_i,
  input  logic [SRC_N-1:0]  reg_wdata_i,
  output logic [SRC_N-1:0]  reg_rdata_o,
  input  logic [SRC_N-1:0]  evt_i,
  input  logic [SRC_N-1:0]  cond_i,
  input  logic              sleep_i,
  input  logic              bus_act_i,
  output logic              irq_no,
  output logic [CODE_W-1:0] icode_o,
  output logic              wake_req_o
);
  logic [SRC_N-1:0] en_q, flag_q, set_v, mask_v, pend;
  logic             wake_det;

  assign mask_v = reg_mod_i ? reg_mask_i : '1;

  always_comb begin
    set_v = evt_i;
    set_v[irq_pkg::B_WAKE] = evt_i[irq_pkg::B_WAKE] | wake_det;
  end

  irq_flag_bank #(.N(SRC_N)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_we_i (reg_wr_i & ~reg_sel_i),
    .fl_we_i (reg_wr_i & reg_sel_i),
    .mask_i  (mask_v),
    .wdata_i (reg_wdata_i),
    .set_i   (set_v),
    .hold_i  (cond_i),
    .en_o    (en_q),
    .flag_o  (flag_q)
  );

  irq_wake_det u_wake (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sleep_i   (sleep_i),
    .bus_act_i (bus_act_i),
    .wake_en_i (en_q[irq_pkg::B_WAKE]),
    .det_o     (wake_det),
    .req_o     (wake_req_o)
  );

  assign pend = en_q & flag_q;

  irq_prio_enc #(.N(SRC_N), .CODE_W(CODE_W)) u_enc (
    .pend_i (pend),
    .code_o (icode_o)
  );

  assign irq_no      = ~|pend;
  assign reg_rdata_o = reg_sel_i ? flag_q : en_q;
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk #(
  parameter int unsigned SRC_N  = irq_pkg::SRC_N,
  parameter int unsigned CODE_W = irq_pkg::CODE_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [SRC_N-1:0]  en_q,
  input logic [SRC_N-1:0]  flag_q,
  input logic [SRC_N-1:0]  evt_i,
  input logic [SRC_N-1:0]  cond_i,
  input logic              sleep_i,
  input logic              bus_act_i,
  input logic              irq_no,
  input logic [CODE_W-1:0] icode_o,
  input logic              wake_req_o
);
  import irq_pkg::*;

  assert_code_irq_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (icode_o != '0) |-> !irq_no);

  assert_code_pending_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (icode_o != '0) |-> (en_q[code_src(icode_o)] && flag_q[code_src(icode_o)]));

  assert_merr_irq_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q[B_MERR] && flag_q[B_MERR]) |-> !irq_no);

  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flag_q & cond_i) != '0) |=> ((flag_q & $past(flag_q & cond_i)) == $past(flag_q & cond_i)));

  for (genvar i = 0; i < SRC_N; i++) begin : g_evt
    assert_set_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[i] |=> flag_q[i]);
  end

  assert_wake_flag_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_i && bus_act_i && en_q[B_WAKE]) |=> flag_q[B_WAKE]);

  assert_wake_cause_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_req_o |-> $past(sleep_i && bus_act_i && en_q[B_WAKE]));
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk #(.SRC_N(SRC_N), .CODE_W(CODE_W)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_q       (en_q),
  .flag_q     (flag_q),
  .evt_i      (evt_i),
  .cond_i     (cond_i),
  .sleep_i    (sleep_i),
  .bus_act_i  (bus_act_i),
  .irq_no     (irq_no),
  .icode_o    (icode_o),
  .wake_req_o (wake_req_o)
);

// File: tb/irq_flag_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_flag_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_sel = 1'b0, reg_wr = 1'b0, reg_mod = 1'b0;
  logic [7:0] reg_mask = '0, reg_wdata = '0, reg_rdata;
  logic [7:0] evt = '0, cond = '0;
  logic       sleep = 1'b0, bus_act = 1'b0;
  logic       irq_n, wake_req;
  logic [2:0] icode;
  int         total = 0, bad = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  irq_flag_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_sel_i(reg_sel), .reg_wr_i(reg_wr),
    .reg_mod_i(reg_mod), .reg_mask_i(reg_mask), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .evt_i(evt), .cond_i(cond), .sleep_i(sleep),
    .bus_act_i(bus_act), .irq_no(irq_n), .icode_o(icode), .wake_req_o(wake_req)
  );

  typedef struct packed {
    logic [7:0] en;
    logic [7:0] fl;
    logic [2:0] code;
    logic       irq_n;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{8'hFF, 8'h00, 3'd0, 1'b1},
    '{8'hFF, 8'hFF, 3'd1, 1'b0},
    '{8'hFF, 8'h03, 3'd6, 1'b0},
    '{8'hFF, 8'h02, 3'd7, 1'b0},
    '{8'hFF, 8'h1C, 3'd3, 1'b0},
    '{8'hBF, 8'hFF, 3'd2, 1'b0},
    '{8'h80, 8'h80, 3'd0, 1'b0},
    '{8'h00, 8'hFF, 3'd0, 1'b1},
    '{8'h18, 8'h3C, 3'd4, 1'b0},
    '{8'h10, 8'h10, 3'd5, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic sel, input logic [7:0] d,
                           input logic mod, input logic [7:0] m);
    @(negedge clk);
    reg_sel = sel; reg_wr = 1'b1; reg_mod = mod; reg_mask = m; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_mod = 1'b0;
  endtask

  task automatic reg_read(input logic sel, output logic [7:0] d);
    reg_sel = sel;
    #1;
    d = reg_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    // R1 reset state
    reg_read(1'b0, rd); check("R1 enable reg", rd, 8'h00);
    reg_read(1'b1, rd); check("R1 flag reg", rd, 8'h00);
    check("R1 irq_no", irq_n, 1'b1);
    check("R1 icode", icode, 3'd0);
    check("R1 wake_req", wake_req, 1'b0);
    rst_n = 1'b1;

    // R3 full write and readback
    reg_write(1'b0, 8'hA5, 1'b0, 8'h00);
    reg_read(1'b0, rd); check("R3 enable readback", rd, 8'hA5);
    reg_write(1'b1, 8'h5A, 1'b0, 8'h00);
    reg_read(1'b1, rd); check("R3 flag readback", rd, 8'h5A);

    // R5 R8 R9 R10 table
    for (int i = 0; i < 10; i++) begin
      reg_write(1'b0, VEC[i].en, 1'b0, 8'h00);
      reg_write(1'b1, VEC[i].fl, 1'b0, 8'h00);
      check($sformatf("R8 R9 R10 code vec%0d", i), icode, VEC[i].code);
      check($sformatf("R5 R10 irq vec%0d", i), irq_n, VEC[i].irq_n);
    end

    // R2 strobe sets sticky flag
    reg_write(1'b0, 8'h00, 1'b0, 8'h00);
    reg_write(1'b1, 8'h00, 1'b0, 8'h00);
    @(negedge clk); evt = 8'h04;
    @(negedge clk); evt = 8'h00;
    @(negedge clk);
    reg_read(1'b1, rd); check("R2 strobe sticky", rd, 8'h04);

    // R4 bit-modify
    reg_write(1'b1, 8'h0F, 1'b0, 8'h00);
    reg_write(1'b1, 8'h00, 1'b1, 8'h05);
    reg_read(1'b1, rd); check("R4 flag bit-modify", rd, 8'h0A);
    reg_write(1'b0, 8'hFF, 1'b1, 8'h30);
    reg_read(1'b0, rd); check("R4 enable bit-modify", rd, 8'h30);

    // R6 clear blocked by condition
    reg_write(1'b1, 8'h08, 1'b0, 8'h00);
    cond = 8'h08;
    reg_write(1'b1, 8'h00, 1'b0, 8'h00);
    reg_read(1'b1, rd); check("R6 clear blocked", rd, 8'h08);
    cond = 8'h00;
    reg_write(1'b1, 8'h00, 1'b0, 8'h00);
    reg_read(1'b1, rd); check("R6 clear after release", rd, 8'h00);

    // R7 set wins over same-cycle clear
    reg_write(1'b1, 8'h02, 1'b0, 8'h00);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_mod = 1'b1; reg_mask = 8'h02; reg_wdata = 8'h00;
    evt = 8'h02;
    @(negedge clk);
    reg_wr = 1'b0; reg_mod = 1'b0; evt = 8'h00;
    reg_read(1'b1, rd); check("R7 set wins", rd, 8'h02);

    // R9 code advances after clearing the winner; R5 host-set irq
    reg_write(1'b0, 8'hFF, 1'b0, 8'h00);
    reg_write(1'b1, 8'h44, 1'b0, 8'h00);
    check("R9 winner err", icode, 3'd1);
    check("R5 host set irq", irq_n, 1'b0);
    reg_write(1'b1, 8'h00, 1'b1, 8'h40);
    check("R9 next tx0", icode, 3'd3);

    // R11 wakeup
    reg_write(1'b1, 8'h00, 1'b0, 8'h00);
    reg_write(1'b0, 8'h20, 1'b0, 8'h00);
    @(negedge clk); bus_act = 1'b1;
    @(negedge clk);
    reg_read(1'b1, rd); check("R11 awake no flag", rd, 8'h00);
    check("R11 awake no req", wake_req, 1'b0);
    sleep = 1'b1;
    @(negedge clk);
    check("R11 req pulse", wake_req, 1'b1);
    reg_read(1'b1, rd); check("R11 wake flag", rd, 8'h20);
    check("R11 wake code", icode, 3'd2);
    @(negedge clk);
    check("R11 single pulse", wake_req, 1'b0);
    sleep = 1'b0; bus_act = 1'b0;
    reg_write(1'b1, 8'h00, 1'b0, 8'h00);
    reg_write(1'b0, 8'h00, 1'b0, 8'h00);
    @(negedge clk); sleep = 1'b1; bus_act = 1'b1;
    @(negedge clk);
    check("R11 disabled no req", wake_req, 1'b0);
    reg_read(1'b1, rd); check("R11 disabled no flag", rd, 8'h00);
    sleep = 1'b0; bus_act = 1'b0;

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule